// File: doc/BRIEF.md
# Flyback Supply and Fault Supervisor

This block is the digital supervisor of an offline flyback LED controller that starts itself from the rectified mains. Analog comparators outside the block report where the supply rail sits relative to its turn-on, turn-off and power-down-reset thresholds. They also report a rail over-voltage, a feedback voltage pinned at its overload level and an over-temperature condition. From these flags the supervisor decides whether the power switch may be driven. While the chip is not yet powered, it also controls the high-voltage startup current source.

All six flags are asynchronous and pass through a two-stage synchronizer. Undervoltage lockout uses two separate flags, so the hysteresis window is held in a single powered-state register. A persistent overload must last a programmable number of clock-enable ticks before it trips. The trip then blocks switching until the supply has collapsed four times. A rail over-voltage blocks switching until the next turn-on, and over-temperature blocks it for as long as the flag is set.

Top module: `flyback_supervisor`

## Requirements
- R1: While reset is held, gate_en_o is 0, start_src_en_o is 1 and start_hi_o is 0; the power-down-reset synchronizer resets to "below".
- R2: With the turn-off flag low, a rising turn-on flag powers the block; three clock cycles after the flag changes, start_src_en_o is 0 and gate_en_o is 1 (when no fault is pending).
- R3: Once powered, dropping the turn-on flag alone keeps the block powered; asserting the turn-off flag unpowers it three cycles later (start_src_en_o 1, gate_en_o 0).
- R4: While unpowered, start_hi_o is 1 exactly when the power-down-reset flag is low, two cycles after that flag changes; start_hi_o is 0 while powered.
- R5: An overload trip needs the overload flag to stay set for OLP_DLY_TICKS ticks of tick_i in a row; any clear restarts the count; a trip forces gate_en_o to 0.
- R6: After an overload trip, switching resumes only at the turn-on that follows the fourth supply turn-off event; earlier turn-ons leave gate_en_o at 0.
- R7: While the overload latch is set, gate_en_o stays 0 even when powered, and the overload flag has no effect.
- R8: A rail over-voltage flag forces gate_en_o to 0 two cycles later and keeps it 0 after the flag clears, until the next turn-on.
- R9: An over-temperature flag forces gate_en_o to 0 two cycles later; gate_en_o returns to 1 two cycles after the flag clears, with no latching.
- R10: The overload delay advances only on cycles where tick_i is 1; with tick_i held at 0, no overload trip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock enable for the overload delay |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_low_i | input | 1 | Supply below turn-off level |
| vcc_pdr_i | input | 1 | Supply below power-down-reset level |
| vcc_ovp_i | input | 1 | Supply over-voltage |
| fb_ovl_i | input | 1 | Feedback above overload level |
| hot_i | input | 1 | Over-temperature |
| gate_en_o | output | 1 | Permission to switch the power device |
| start_src_en_o | output | 1 | Startup current source enable |
| start_hi_o | output | 1 | Startup current level, 1 = high |

## Verification
Flags reach the decision logic after two synchronizer edges. Outputs that depend only on a synchronized flag therefore change after the second rising edge: over-voltage, over-temperature and the current-level select. Outputs that go through the powered-state register change after the third edge. The bench drives every input on a falling edge and samples on the falling edge after exactly two or three rising edges. Overload timing depends on the tick cadence, so the bench brackets it instead: it checks that the gate is still enabled well before the delay and disabled well after it.

// File: rtl/flyback_supervisor.sv
`timescale 1ns/1ps
module flyback_supervisor #(
  parameter int OLP_DLY_TICKS  = 270,
  parameter int RECOVER_EVENTS = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic vcc_on_i,
  input  logic vcc_low_i,
  input  logic vcc_pdr_i,
  input  logic vcc_ovp_i,
  input  logic fb_ovl_i,
  input  logic hot_i,
  output logic gate_en_o,
  output logic start_src_en_o,
  output logic start_hi_o
);
  localparam int NFLAG = 6;
  localparam int DLY_W = (OLP_DLY_TICKS > 1) ? $clog2(OLP_DLY_TICKS) : 1;
  localparam int REC_W = (RECOVER_EVENTS > 1) ? $clog2(RECOVER_EVENTS) : 1;
  localparam int F_ON = 0, F_LOW = 1, F_PDR = 2, F_OVP = 3, F_OVL = 4, F_HOT = 5;
  localparam logic [NFLAG-1:0] SYNC_RST = 6'b000110;

  logic [NFLAG-1:0] raw, flags;
  logic [SYNC_STAGES-1:0][NFLAG-1:0] sync_q;

  assign raw = {hot_i, fb_ovl_i, vcc_ovp_i, vcc_pdr_i, vcc_low_i, vcc_on_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= {SYNC_STAGES{SYNC_RST}};
    else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign flags = sync_q[SYNC_STAGES-1];

  logic on_s, low_s, pdr_s, ovp_s, ovl_s, hot_s;
  assign on_s  = flags[F_ON];
  assign low_s = flags[F_LOW];
  assign pdr_s = flags[F_PDR];
  assign ovp_s = flags[F_OVP];
  assign ovl_s = flags[F_OVL];
  assign hot_s = flags[F_HOT];

  logic powered_q, olp_q, ovp_q;
  logic [DLY_W-1:0] dly_cnt;
  logic [REC_W-1:0] rec_cnt;
  logic on_evt, off_evt, olp_trip, olp_release;

  assign on_evt      = !powered_q && on_s;
  assign off_evt     = powered_q && low_s;
  assign olp_trip    = tick_i && ovl_s && powered_q && !olp_q &&
                       (dly_cnt == DLY_W'(OLP_DLY_TICKS - 1));
  assign olp_release = olp_q && off_evt && (rec_cnt == REC_W'(RECOVER_EVENTS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       powered_q <= 1'b0;
    else if (on_evt)  powered_q <= 1'b1;
    else if (off_evt) powered_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly_cnt <= '0;
    else if (!ovl_s || !powered_q || olp_q) dly_cnt <= '0;
    else if (tick_i)
      dly_cnt <= (dly_cnt == DLY_W'(OLP_DLY_TICKS - 1)) ? '0 : dly_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           olp_q <= 1'b0;
    else if (olp_trip)    olp_q <= 1'b1;
    else if (olp_release) olp_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                rec_cnt <= '0;
    else if (olp_trip)         rec_cnt <= '0;
    else if (olp_q && off_evt)
      rec_cnt <= (rec_cnt == REC_W'(RECOVER_EVENTS - 1)) ? '0 : rec_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ovp_q <= 1'b0;
    else if (ovp_s)  ovp_q <= 1'b1;
    else if (on_evt) ovp_q <= 1'b0;

  assign gate_en_o      = powered_q && !olp_q && !ovp_q && !ovp_s && !hot_s;
  assign start_src_en_o = !powered_q;
  assign start_hi_o     = !powered_q && !pdr_s;
endmodule

// File: rtl/flyback_supervisor_chk.sv
`timescale 1ns/1ps
module flyback_supervisor_chk #(
  parameter int RECOVER_EVENTS = 4,
  parameter int REC_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic gate_en_o,
  input logic start_src_en_o,
  input logic start_hi_o,
  input logic hot_s,
  input logic ovp_s,
  input logic ovl_s,
  input logic powered_q,
  input logic olp_q,
  input logic ovp_q,
  input logic [REC_W-1:0] rec_cnt
);
  p_gate_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en_o |-> !start_src_en_o);
  p_hi_only_unpowered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_hi_o |-> start_src_en_o);
  p_olp_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(olp_q) |-> $past(ovl_s) && $past(powered_q));
  p_olp_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(olp_q) |-> !powered_q && $past(powered_q) &&
                     ($past(rec_cnt) == REC_W'(RECOVER_EVENTS - 1)));
  p_olp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    olp_q |-> !gate_en_o);
  p_ovp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_s || ovp_q) |-> !gate_en_o);
  p_ovp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovp_q) |-> powered_q && !$past(powered_q));
  p_otp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |-> !gate_en_o);
endmodule

bind flyback_supervisor flyback_supervisor_chk #(
  .RECOVER_EVENTS(RECOVER_EVENTS), .REC_W(REC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en_o(gate_en_o), .start_src_en_o(start_src_en_o),
  .start_hi_o(start_hi_o), .hot_s(hot_s), .ovp_s(ovp_s), .ovl_s(ovl_s),
  .powered_q(powered_q), .olp_q(olp_q), .ovp_q(ovp_q), .rec_cnt(rec_cnt)
);

// File: tb/flyback_supervisor_bench.sv
`timescale 1ns/1ps
module flyback_supervisor_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tick_en = 1'b0;
  logic on = 1'b0, low = 1'b1, pdr = 1'b1, ovp = 1'b0, ovl = 1'b0, hot = 1'b0;
  logic gate, src, hi;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(negedge clk) tick <= tick_en ? ~tick : 1'b0;

  flyback_supervisor #(.OLP_DLY_TICKS(8)) u_flyback_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .vcc_on_i(on), .vcc_low_i(low),
    .vcc_pdr_i(pdr), .vcc_ovp_i(ovp), .fb_ovl_i(ovl), .hot_i(hot),
    .gate_en_o(gate), .start_src_en_o(src), .start_hi_o(hi));

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic power_up;
    low = 1'b0; on = 1'b1; wcyc(4); on = 1'b0; wcyc(1);
  endtask

  task automatic power_down;
    low = 1'b1; wcyc(4); low = 1'b0; wcyc(1);
  endtask

  task automatic t_reset;
    wcyc(3);
    chk(gate, 1'b0, "R1 gate in reset");
    chk(src, 1'b1, "R1 source in reset");
    chk(hi, 1'b0, "R1 level in reset");
    rst_n = 1'b1; wcyc(2);
  endtask

  task automatic t_startup;
    pdr = 1'b0; wcyc(2);
    chk(hi, 1'b1, "R4 high level above pdr");
    pdr = 1'b1; wcyc(2);
    chk(hi, 1'b0, "R4 low level below pdr");
    pdr = 1'b0; low = 1'b0; wcyc(2);
    on = 1'b1; wcyc(2);
    chk(src, 1'b1, "R2 source still on at cycle 2");
    wcyc(1);
    chk(src, 1'b0, "R2 source off at cycle 3");
    chk(gate, 1'b1, "R2 gate on at cycle 3");
    chk(hi, 1'b0, "R4 level low while powered");
  endtask

  task automatic t_hyst;
    on = 1'b0; wcyc(5);
    chk(src, 1'b0, "R3 stays powered in window");
    chk(gate, 1'b1, "R3 gate kept in window");
    low = 1'b1; wcyc(3);
    chk(src, 1'b1, "R3 unpowered on low flag");
    chk(gate, 1'b0, "R3 gate off on low flag");
    chk(hi, 1'b1, "R4 high level when unpowered");
    low = 1'b0; wcyc(1);
    power_up();
  endtask

  task automatic t_otp;
    hot = 1'b1; wcyc(2);
    chk(gate, 1'b0, "R9 gate off when hot");
    hot = 1'b0; wcyc(2);
    chk(gate, 1'b1, "R9 gate back when cool");
  endtask

  task automatic t_ovp;
    ovp = 1'b1; wcyc(2);
    chk(gate, 1'b0, "R8 gate off on ovp");
    ovp = 1'b0; wcyc(6);
    chk(gate, 1'b0, "R8 gate held after ovp clears");
    chk(src, 1'b0, "R8 still powered");
    power_down(); power_up();
    chk(gate, 1'b1, "R8 gate back after turn-on");
  endtask

  task automatic t_olp_filter;
    tick_en = 1'b0; ovl = 1'b1; wcyc(40);
    chk(gate, 1'b1, "R10 no trip without ticks");
    tick_en = 1'b1; wcyc(10);
    chk(gate, 1'b1, "R5 no trip before delay");
    ovl = 1'b0; wcyc(4);
    ovl = 1'b1; wcyc(10);
    chk(gate, 1'b1, "R5 delay restarted by clear");
    wcyc(30);
    chk(gate, 1'b0, "R5 trip after delay");
  endtask

  task automatic t_olp_recover;
    wcyc(4);
    chk(gate, 1'b0, "R7 latched with flag held");
    chk(src, 1'b0, "R7 still powered while latched");
    ovl = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      power_down(); power_up();
      chk(gate, 1'b0, $sformatf("R6 still off after event %0d", k));
    end
    power_down();
    chk(src, 1'b1, "R6 unpowered after fourth event");
    power_up();
    chk(gate, 1'b1, "R6 switching resumes");
  endtask

  initial begin
    t_reset();
    t_startup();
    t_hyst();
    t_otp();
    t_ovp();
    t_olp_filter();
    t_olp_recover();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule